// File: doc/BRIEF.md
# Voltage-and-Opcode Debug Trigger

This block raises the stop pulse for a trace recorder. In every cycle it compares a digital supply-voltage code from an on-chip delay-line sensor with a threshold, and it compares the opcode of the executing instruction with a selected entry of a small opcode list. A lower code means a lower supply. When both terms agree, the cycle counts as a qualifying hit. A host arms the block and sets how many hits to pass over before the trigger fires. Successive debug runs can then stop at successively later occurrences. A running hit total since the last arm tells the host how many runs a full walk needs.

The threshold and the opcode both come from a sweep state that the host advances with a single step strobe. One sweep order holds the opcode and raises the threshold, then moves to the next opcode. The other holds the threshold and cycles through the opcode list, then raises the threshold. Enabled logical-fault event bits (interrupt, divide by zero, illegal instruction, bad memory access) fire the trigger at once while the block is armed.

Top module: `volt_op_trigger`

## Requirements
- R1: After reset `trig`, `armed`, `hit_total`, `thr_idx` and `op_idx` are all zero.
- R2: A cycle is a hit when `instr_valid` is 1, the masked opcode equals list entry `op_idx` (entry i occupies bits [i*OPW +: OPW] of `cfg_op_list`), and, with `cfg_volt_en`=1, `volt_code` <= `cur_thr`.
- R3: With `cfg_volt_en`=0 the voltage code has no effect, so an opcode match alone is a hit.
- R4: Opcode bits whose `cfg_op_mask` bit is 0 are ignored in the comparison.
- R5: While armed, any `fault_evt` bit whose `cfg_fault_en` bit is 1 makes `trig` high after the next clock edge, regardless of the hit count.
- R6: While armed, a hit that arrives when `hit_total` equals `cfg_skip` makes `trig` high for exactly one cycle after that edge and clears `armed`. No further trigger occurs until `arm` is pulsed again.
- R7: `hit_total` counts hits since the last `arm` pulse or reset, saturating at all ones. A hit in the same cycle as `arm` is not counted.
- R8: `sweep_load` sets `thr_idx` and `op_idx` to 0 and `cur_thr` to `cfg_thr_low`. It takes priority over `sweep_step`.
- R9: With `cfg_sweep_mode`=0, each `sweep_step` raises `cur_thr` by `cfg_thr_step` and increments `thr_idx`. At `thr_idx`=`cfg_thr_last` it wraps the threshold to `cfg_thr_low` and advances `op_idx`, which wraps after `cfg_op_last`.
- R10: With `cfg_sweep_mode`=1, each `sweep_step` advances `op_idx`. At `op_idx`=`cfg_op_last` it wraps to 0 and advances the threshold as in R9.
- R11: Raising the threshold saturates `cur_thr` at all ones instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| volt_code | input | VW | Per-cycle sensed voltage code |
| instr_valid | input | 1 | An instruction executes this cycle |
| instr_op | input | OPW | Opcode of the executing instruction |
| fault_evt | input | NFLT | Logical fault event bits |
| cfg_volt_en | input | 1 | Enable the voltage term |
| cfg_thr_low | input | VW | Lowest (starting) threshold code |
| cfg_thr_step | input | VW | Threshold increment per step |
| cfg_thr_last | input | TIW | Last threshold index before wrap |
| cfg_op_list | input | NOPS*OPW | Ordered opcode list |
| cfg_op_last | input | OIW | Last opcode index before wrap |
| cfg_op_mask | input | OPW | Opcode compare mask |
| cfg_fault_en | input | NFLT | Fault event enables |
| cfg_skip | input | CNTW | Hits to pass over before firing |
| cfg_sweep_mode | input | 1 | 0: step threshold first, 1: step opcode first |
| sweep_load | input | 1 | Restart the sweep |
| sweep_step | input | 1 | Advance the sweep |
| arm | input | 1 | Arm and clear the hit total |
| trig | output | 1 | One-cycle stop trigger |
| armed | output | 1 | Block is armed |
| hit_total | output | CNTW | Hits since last arm |
| cur_thr | output | VW | Current threshold code |
| thr_idx | output | TIW | Current threshold index |
| op_idx | output | OIW | Current opcode list index |

## Verification
The bench probes a voltage exactly at the threshold and one code above it. A design with a strict compare would miss the first, and one with an inverted compare would take the second. It fires on the k-th hit and then offers a further hit. An off-by-one count fires a cycle early or late, and a missing disarm pulses twice. It also covers a hit coincident with `arm`, the wrap points of both sweep orders, and threshold and count saturation. Wrong priority there shows up as a stray count, a skipped opcode, or a threshold that wraps to a small value.

// File: rtl/volt_op_trigger.sv
module volt_op_trigger #(
  parameter int VW   = 8,
  parameter int OPW  = 8,
  parameter int NFLT = 4,
  parameter int NOPS = 4,
  parameter int NTHR = 8,
  parameter int CNTW = 16,
  localparam int OIW = (NOPS > 1) ? $clog2(NOPS) : 1,
  localparam int TIW = (NTHR > 1) ? $clog2(NTHR) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [VW-1:0]        volt_code,
  input  logic                 instr_valid,
  input  logic [OPW-1:0]       instr_op,
  input  logic [NFLT-1:0]      fault_evt,
  input  logic                 cfg_volt_en,
  input  logic [VW-1:0]        cfg_thr_low,
  input  logic [VW-1:0]        cfg_thr_step,
  input  logic [TIW-1:0]       cfg_thr_last,
  input  logic [NOPS*OPW-1:0]  cfg_op_list,
  input  logic [OIW-1:0]       cfg_op_last,
  input  logic [OPW-1:0]       cfg_op_mask,
  input  logic [NFLT-1:0]      cfg_fault_en,
  input  logic [CNTW-1:0]      cfg_skip,
  input  logic                 cfg_sweep_mode,
  input  logic                 sweep_load,
  input  logic                 sweep_step,
  input  logic                 arm,
  output logic                 trig,
  output logic                 armed,
  output logic [CNTW-1:0]      hit_total,
  output logic [VW-1:0]        cur_thr,
  output logic [TIW-1:0]       thr_idx,
  output logic [OIW-1:0]       op_idx
);

  localparam logic [CNTW-1:0] CMAX = {CNTW{1'b1}};
  localparam logic [VW-1:0]   VMAX = {VW{1'b1}};

  logic [OPW-1:0] sel_op;
  logic           op_ok, volt_ok, hit, flt, fire;
  logic [VW:0]    thr_sum;
  logic [VW-1:0]  thr_up;
  logic           thr_wrap, op_wrap;

  assign sel_op  = cfg_op_list[int'(op_idx)*OPW +: OPW];
  assign op_ok   = ((instr_op ^ sel_op) & cfg_op_mask) == '0;
  assign volt_ok = !cfg_volt_en || (volt_code <= cur_thr);
  assign hit     = instr_valid && op_ok && volt_ok;
  assign flt     = |(fault_evt & cfg_fault_en);
  assign fire    = armed && ((hit && hit_total == cfg_skip) || flt);

  assign thr_sum  = {1'b0, cur_thr} + {1'b0, cfg_thr_step};
  assign thr_up   = thr_sum[VW] ? VMAX : thr_sum[VW-1:0];
  assign thr_wrap = (thr_idx == cfg_thr_last) || (int'(thr_idx) == NTHR - 1);
  assign op_wrap  = (op_idx == cfg_op_last) || (int'(op_idx) == NOPS - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trig      <= 1'b0;
      armed     <= 1'b0;
      hit_total <= '0;
    end else begin
      trig <= 1'b0;
      if (arm) begin
        armed     <= 1'b1;
        hit_total <= '0;
      end else begin
        if (hit && hit_total != CMAX) hit_total <= hit_total + 1'b1;
        if (fire) begin
          trig  <= 1'b1;
          armed <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_thr <= '0;
      thr_idx <= '0;
      op_idx  <= '0;
    end else if (sweep_load) begin
      cur_thr <= cfg_thr_low;
      thr_idx <= '0;
      op_idx  <= '0;
    end else if (sweep_step) begin
      if (!cfg_sweep_mode) begin
        if (thr_wrap) begin
          thr_idx <= '0;
          cur_thr <= cfg_thr_low;
          op_idx  <= op_wrap ? '0 : op_idx + 1'b1;
        end else begin
          thr_idx <= thr_idx + 1'b1;
          cur_thr <= thr_up;
        end
      end else begin
        if (op_wrap) begin
          op_idx <= '0;
          if (thr_wrap) begin
            thr_idx <= '0;
            cur_thr <= cfg_thr_low;
          end else begin
            thr_idx <= thr_idx + 1'b1;
            cur_thr <= thr_up;
          end
        end else begin
          op_idx <= op_idx + 1'b1;
        end
      end
    end
  end

  p_fault_fires_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !arm && |(fault_evt & cfg_fault_en)) |=> trig);

  p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> !trig);

  p_needs_arm_r6: assert property (@(posedge clk) disable iff (!rst_n)
    trig |-> !armed && $past(armed));

  p_total_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> hit_total == '0);

  p_total_sat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_total == CMAX && !arm) |=> hit_total == CMAX);

  p_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_load |=> (thr_idx == '0 && op_idx == '0));

  p_thr_rises_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (sweep_step && !sweep_load && !cfg_sweep_mode && !thr_wrap) |=> cur_thr >= $past(cur_thr));

endmodule

// File: tb/tb_volt_op_trigger.sv
module tb_volt_op_trigger;
  localparam int VW = 8, OPW = 8, NFLT = 4, NOPS = 4, NTHR = 8, CNTW = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic [VW-1:0] volt_code;
  logic instr_valid;
  logic [OPW-1:0] instr_op;
  logic [NFLT-1:0] fault_evt;
  logic cfg_volt_en;
  logic [VW-1:0] cfg_thr_low, cfg_thr_step;
  logic [2:0] cfg_thr_last;
  logic [NOPS*OPW-1:0] cfg_op_list;
  logic [1:0] cfg_op_last;
  logic [OPW-1:0] cfg_op_mask;
  logic [NFLT-1:0] cfg_fault_en;
  logic [CNTW-1:0] cfg_skip;
  logic cfg_sweep_mode, sweep_load, sweep_step, arm;
  logic trig, armed;
  logic [CNTW-1:0] hit_total;
  logic [VW-1:0] cur_thr;
  logic [2:0] thr_idx;
  logic [1:0] op_idx;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  volt_op_trigger #(.VW(VW), .OPW(OPW), .NFLT(NFLT), .NOPS(NOPS), .NTHR(NTHR), .CNTW(CNTW)) dut (
    .clk(clk), .rst_n(rst_n), .volt_code(volt_code), .instr_valid(instr_valid),
    .instr_op(instr_op), .fault_evt(fault_evt), .cfg_volt_en(cfg_volt_en),
    .cfg_thr_low(cfg_thr_low), .cfg_thr_step(cfg_thr_step), .cfg_thr_last(cfg_thr_last),
    .cfg_op_list(cfg_op_list), .cfg_op_last(cfg_op_last), .cfg_op_mask(cfg_op_mask),
    .cfg_fault_en(cfg_fault_en), .cfg_skip(cfg_skip), .cfg_sweep_mode(cfg_sweep_mode),
    .sweep_load(sweep_load), .sweep_step(sweep_step), .arm(arm), .trig(trig),
    .armed(armed), .hit_total(hit_total), .cur_thr(cur_thr), .thr_idx(thr_idx), .op_idx(op_idx));

  // {volt_code, instr_op, instr_valid, expected hit}
  localparam logic [17:0] VEC [0:7] = '{
    {8'd100, 8'h21, 1'b1, 1'b1},
    {8'd101, 8'h21, 1'b1, 1'b0},
    {8'd50,  8'h21, 1'b1, 1'b1},
    {8'd50,  8'h22, 1'b1, 1'b0},
    {8'd50,  8'h21, 1'b0, 1'b0},
    {8'd0,   8'h21, 1'b1, 1'b1},
    {8'd255, 8'h33, 1'b1, 1'b0},
    {8'd99,  8'h21, 1'b1, 1'b1}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick;
    @(negedge clk);
  endtask

  task automatic idle;
    instr_valid = 0; fault_evt = '0; arm = 0; sweep_load = 0; sweep_step = 0;
  endtask

  task automatic do_arm;
    idle(); arm = 1; tick(); arm = 0;
  endtask

  task automatic do_load;
    idle(); sweep_load = 1; tick(); sweep_load = 0;
  endtask

  task automatic do_step;
    idle(); sweep_step = 1; tick(); sweep_step = 0;
  endtask

  task automatic hit_once(input logic [7:0] v, input logic [7:0] op);
    volt_code = v; instr_op = op; instr_valid = 1; tick(); instr_valid = 0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; idle(); volt_code = '0; instr_op = '0;
    cfg_volt_en = 1; cfg_thr_low = 8'd100; cfg_thr_step = 8'd10; cfg_thr_last = 3'd3;
    cfg_op_list = {8'h55, 8'h4C, 8'h33, 8'h21}; cfg_op_last = 2'd2; cfg_op_mask = 8'hFF;
    cfg_fault_en = '0; cfg_skip = 4'hF; cfg_sweep_mode = 0;
    tick(); tick();
    rst_n = 1; tick();
    // R1 reset state
    check("R1 trig", trig, 0); check("R1 armed", armed, 0); check("R1 total", hit_total, 0);
    check("R1 thr_idx", thr_idx, 0); check("R1 op_idx", op_idx, 0);

    do_load();
    check("R8 cur_thr", cur_thr, 100);

    // R2 table walk, threshold 100, opcode 0x21, skip 15 so no fire
    do_arm();
    begin
      int exp_tot = 0;
      for (int i = 0; i < 8; i++) begin
        volt_code = VEC[i][17:10]; instr_op = VEC[i][9:2]; instr_valid = VEC[i][1];
        tick();
        exp_tot += int'(VEC[i][0]);
        check($sformatf("R2 vec%0d total", i), hit_total, exp_tot);
        check($sformatf("R2 vec%0d trig", i), trig, 0);
      end
      instr_valid = 0;
    end

    // R3 voltage term disabled
    do_arm(); cfg_volt_en = 0;
    hit_once(8'd255, 8'h21);
    check("R3 total", hit_total, 1);
    cfg_volt_en = 1;

    // R4 mask
    do_arm(); cfg_op_mask = 8'hF0;
    hit_once(8'd10, 8'h2A);
    check("R4 masked match", hit_total, 1);
    cfg_op_mask = 8'hFF;
    hit_once(8'd10, 8'h2A);
    check("R4 full mask miss", hit_total, 1);

    // R6 fire on third hit (skip 2)
    cfg_skip = 4'd2; do_arm();
    hit_once(8'd10, 8'h21); check("R6 first no trig", trig, 0);
    hit_once(8'd10, 8'h21); check("R6 second no trig", trig, 0);
    hit_once(8'd10, 8'h21); check("R6 third trig", trig, 1); check("R6 disarm", armed, 0);
    tick(); check("R6 one cycle", trig, 0);
    hit_once(8'd10, 8'h21); check("R6 no refire", trig, 0); check("R7 still counts", hit_total, 4);
    cfg_skip = 4'hF;

    // R7 hit in arm cycle not counted
    idle(); arm = 1; volt_code = 8'd10; instr_op = 8'h21; instr_valid = 1; tick(); idle();
    check("R7 arm-cycle hit", hit_total, 0); check("R7 armed", armed, 1);

    // R7 saturation
    volt_code = 8'd10; instr_op = 8'h21; instr_valid = 1;
    for (int i = 0; i < 20; i++) tick();
    instr_valid = 0;
    check("R7 saturate", hit_total, 15);

    // R5 fault trigger
    cfg_fault_en = 4'b0100; do_arm();
    fault_evt = 4'b0001; tick(); fault_evt = '0;
    check("R5 disabled fault", trig, 0);
    fault_evt = 4'b0100; tick(); fault_evt = '0;
    check("R5 enabled fault", trig, 1);
    cfg_fault_en = '0;

    // R9 mode 0
    cfg_sweep_mode = 0; do_load();
    do_step(); check("R9 thr 110", cur_thr, 110); check("R9 idx1", thr_idx, 1);
    do_step(); do_step(); check("R9 thr 130", cur_thr, 130); check("R9 op held", op_idx, 0);
    do_step(); check("R9 wrap thr", cur_thr, 100); check("R9 wrap idx", thr_idx, 0);
    check("R9 op advance", op_idx, 1);

    // R10 mode 1
    cfg_sweep_mode = 1; do_load();
    do_step(); check("R10 op1", op_idx, 1); check("R10 thr held", cur_thr, 100);
    do_arm(); hit_once(8'd90, 8'h33); check("R2 list entry 1", hit_total, 1);
    do_step(); check("R10 op2", op_idx, 2);
    do_step(); check("R10 op wrap", op_idx, 0); check("R10 thr idx", thr_idx, 1);
    check("R10 thr 110", cur_thr, 110);

    // R8 load beats step
    idle(); sweep_load = 1; sweep_step = 1; tick(); idle();
    check("R8 priority op", op_idx, 0); check("R8 priority thr", cur_thr, 100);

    // R11 saturation
    cfg_sweep_mode = 0; cfg_thr_low = 8'd250; do_load();
    do_step(); check("R11 saturate", cur_thr, 255);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule